// File: doc/BRIEF.md
# Routed Interrupt Controller

This block gathers 32 external interrupt request lines and turns them into sixteen interrupt outputs: four cores, each with four interrupt pins. Each request line passes through a two-flop synchroniser. It is then captured either as a level or as an edge, and the active sense is selectable per source. The captured state is qualified by a per-source enable mask and steered to one or more outputs by a per-source routing byte.

Software reaches the block through a simple word-wide register bus. The bus carries a byte address, write data, byte-lane enables and a write strobe, and read data comes back combinationally. Enables are changed only through separate set and clear registers, so one source can be masked without disturbing the others. Edge-captured requests stay latched until software clears them.

Top module: `irq_router_top`

## Requirements
- R1: After reset, all enable, polarity and edge-mode bits are 0, and every routing byte reads 0x11.
- R2: Offsets 0x00-0x1C hold the routing bytes. Source s uses byte lane s%4 of the word at offset 4*(s/4). A write updates only the lanes whose byte enable is 1.
- R3: A write to offset 0x28 sets each enable bit whose data bit is 1 within an enabled byte lane. All other enable bits are unchanged. A read of 0x28 returns the enable mask.
- R4: A write to offset 0x2C clears each enable bit whose data bit is 1 within an enabled byte lane. All other enable bits are unchanged. A read of 0x2C returns 0.
- R5: In level mode (edge bit at 0x38 is 0), raw status bit s (read at 0x20) equals the synchronised input XNOR polarity bit s (at 0x30). An input change shows in the raw status after two clock edges.
- R6: In edge mode (edge bit 1), a rising edge (polarity 1) or a falling edge (polarity 0) sets a sticky raw status bit. A 1 written to that bit at 0x20 in an enabled byte lane clears it. The same write has no effect on level-mode bits.
- R7: Offset 0x24 reads the raw status AND the enable mask.
- R8: Output irq_out[4*c+p] is the OR of every pending source whose routing byte has bit c (core, low nibble) and bit 4+p (pin, high nibble) set. A nibble with no bit set routes nowhere. A nibble with several bits set routes to every selected target.
- R9: Offsets 0x34 and 0x3C, and any address whose two low bits are not 0, read as 0, and writes to them change nothing.
- R10: After 0xFFFFFFFF is written to 0x2C and 0 to 0x38, all outputs stay low and the pending register reads 0, even with every source asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write enables |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | 32 | Asynchronous interrupt request lines |
| irq_out | output | 16 | Interrupt outputs, bit 4*core+pin |

## Verification
The bench steers every source to each of the sixteen targets in turn. A design with a swapped nibble, a wrong lane-to-source mapping or a wrong output index would light the wrong output. Each source is also taken through rising and falling capture, so a design with inverted polarity decode or a non-sticky edge bit would lose the request once the input drops. Writes to the clear and set registers with partial byte enables would expose a design that ignores lanes or lets zero bits clear enables. Writes to unmapped and misaligned offsets, and W1C writes to level-mode bits, would show any decode that leaks into real state.

// File: rtl/irq_router_pkg.sv
// Shared constants for the routed interrupt controller: sizes, register
// word indices and the byte-lane mask helper. Assumes 32 sources, 4 cores,
// 4 pins and a 32-bit data bus.
package irq_router_pkg;
    localparam int NSRC     = 32;
    localparam int NCORE    = 4;
    localparam int NPIN     = 4;
    localparam int DW       = 32;
    localparam int AW       = 6;
    localparam int NLANE    = DW / 8;
    localparam int NTGT     = NCORE * NPIN;
    localparam int RT_WORDS = NSRC / NLANE;
    localparam int WIDX_W   = AW - 2;

    localparam logic [WIDX_W-1:0] W_RAW   = 4'd8;
    localparam logic [WIDX_W-1:0] W_PEND  = 4'd9;
    localparam logic [WIDX_W-1:0] W_ENSET = 4'd10;
    localparam logic [WIDX_W-1:0] W_ENCLR = 4'd11;
    localparam logic [WIDX_W-1:0] W_POL   = 4'd12;
    localparam logic [WIDX_W-1:0] W_EDGE  = 4'd14;

    localparam logic [7:0] ROUTE_RST = 8'h11;

    // Expand byte enables into a bit mask.
    function automatic logic [DW-1:0] lane_mask(input logic [NLANE-1:0] be);
        logic [DW-1:0] m;
        for (int l = 0; l < NLANE; l++) m[8*l +: 8] = {8{be[l]}};
        return m;
    endfunction
endpackage

// File: rtl/irq_sync.sv
// Two-flop synchroniser for a vector of asynchronous lines.
// Assumes each bit is an independent, slowly changing level.
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    // Shift the inputs through two registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/irq_capture.sv
// Per-source trigger capture. Level mode gives input XNOR polarity with no
// stored state. Edge mode latches an edge of the selected sense into a
// sticky bit that a clear mask removes. Assumes sync_in is already
// synchronous to clk.
module irq_capture #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_in,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] clr,
    output logic [N-1:0] raw
);
    logic [N-1:0] prev;

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= sync_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        logic hit;
        logic sticky;

        assign hit = pol[i] ? (sync_in[i] & ~prev[i]) : (~sync_in[i] & prev[i]);

        // Sticky edge flag: a new edge wins over a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)            sticky <= 1'b0;
            else if (!edge_mode[i]) sticky <= 1'b0;
            else if (hit)          sticky <= 1'b1;
            else if (clr[i])       sticky <= 1'b0;
        end

        assign raw[i] = edge_mode[i] ? sticky : ~(sync_in[i] ^ pol[i]);
    end
endmodule

// File: rtl/irq_regs.sv
// Register file: routing bytes, enable mask with set/clear access,
// polarity and edge mode, read mux and the W1C mask for edge status.
// Assumes single-cycle writes and a combinational read.
module irq_regs
    import irq_router_pkg::*;
#(
    parameter int N_SRC = NSRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    input  logic [NLANE-1:0]   bus_be,
    input  logic               bus_we,
    output logic [DW-1:0]      bus_rdata,
    input  logic [N_SRC-1:0]   raw,
    output logic [N_SRC-1:0]   en_q,
    output logic [N_SRC-1:0]   pol_q,
    output logic [N_SRC-1:0]   edge_q,
    output logic [N_SRC-1:0]   w1c,
    output logic [8*N_SRC-1:0] route_q
);
    logic [WIDX_W-1:0] word;
    logic              aligned;
    logic              wr;
    logic [DW-1:0]     bm;
    logic [DW-1:0]     wm;

    assign word    = bus_addr[AW-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr      = bus_we && aligned;
    assign bm      = lane_mask(bus_be);
    assign wm      = bus_wdata & bm;
    assign w1c     = (wr && word == W_RAW) ? wm[N_SRC-1:0] : '0;

    // Enable mask: set and clear only through their own offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else if (wr && word == W_ENSET) en_q <= en_q | wm[N_SRC-1:0];
        else if (wr && word == W_ENCLR) en_q <= en_q & ~wm[N_SRC-1:0];
    end

    // Polarity and edge mode: lane-masked replace.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            edge_q <= '0;
        end else begin
            if (wr && word == W_POL)
                pol_q <= (pol_q & ~bm[N_SRC-1:0]) | wm[N_SRC-1:0];
            if (wr && word == W_EDGE)
                edge_q <= (edge_q & ~bm[N_SRC-1:0]) | wm[N_SRC-1:0];
        end
    end

    // Routing bytes: one lane per source, four sources per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= {N_SRC{ROUTE_RST}};
        end else if (wr) begin
            for (int s = 0; s < N_SRC; s++) begin
                if (int'(word) == s / NLANE && bus_be[s % NLANE])
                    route_q[8*s +: 8] <= bus_wdata[8*(s % NLANE) +: 8];
            end
        end
    end

    // Read mux; unmapped and misaligned offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (int'(word) < RT_WORDS) begin
                bus_rdata = route_q[DW*int'(word) +: DW];
            end else begin
                case (word)
                    W_RAW:   bus_rdata = DW'(raw);
                    W_PEND:  bus_rdata = DW'(raw & en_q);
                    W_ENSET: bus_rdata = DW'(en_q);
                    W_POL:   bus_rdata = DW'(pol_q);
                    W_EDGE:  bus_rdata = DW'(edge_q);
                    default: bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_route.sv
// Routing fabric: each output ORs the pending sources whose routing byte
// selects both its core (low nibble) and its pin (high nibble).
// Assumes one-hot or arbitrary nibbles; several bits fan out.
module irq_route #(
    parameter int N_SRC  = 32,
    parameter int N_CORE = 4,
    parameter int N_PIN  = 4
) (
    input  logic [N_SRC-1:0]        pending,
    input  logic [8*N_SRC-1:0]      route_q,
    output logic [N_CORE*N_PIN-1:0] irq_out
);
    for (genvar c = 0; c < N_CORE; c++) begin : g_core
        for (genvar p = 0; p < N_PIN; p++) begin : g_pin
            logic [N_SRC-1:0] hits;
            for (genvar s = 0; s < N_SRC; s++) begin : g_src
                assign hits[s] = pending[s] & route_q[8*s + c] & route_q[8*s + 4 + p];
            end
            assign irq_out[c*N_PIN + p] = |hits;
        end
    end
endmodule

// File: rtl/irq_router_top.sv
// Top of the routed interrupt controller: synchroniser, capture, register
// file and routing fabric. Assumes irq_in lines are asynchronous and held
// for at least two clock cycles.
module irq_router_top
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [NLANE-1:0]  bus_be,
    input  logic              bus_we,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NSRC-1:0]   irq_in,
    output logic [NTGT-1:0]   irq_out
);
    logic [NSRC-1:0]   sync_in;
    logic [NSRC-1:0]   raw_st;
    logic [NSRC-1:0]   en_mask;
    logic [NSRC-1:0]   pol_mask;
    logic [NSRC-1:0]   edge_mask;
    logic [NSRC-1:0]   w1c;
    logic [8*NSRC-1:0] route_q;
    logic [NSRC-1:0]   pending;

    irq_sync #(.W(NSRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(sync_in)
    );

    irq_capture #(.N(NSRC)) u_cap (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .pol(pol_mask),
        .edge_mode(edge_mask), .clr(w1c), .raw(raw_st)
    );

    irq_regs #(.N_SRC(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_we(bus_we), .bus_rdata(bus_rdata), .raw(raw_st),
        .en_q(en_mask), .pol_q(pol_mask), .edge_q(edge_mask), .w1c(w1c),
        .route_q(route_q)
    );

    assign pending = raw_st & en_mask;

    irq_route #(.N_SRC(NSRC), .N_CORE(NCORE), .N_PIN(NPIN)) u_route (
        .pending(pending), .route_q(route_q), .irq_out(irq_out)
    );
endmodule

// File: rtl/irq_router_chk.sv
// Assertion checker for irq_router_top, attached by bind.
module irq_router_chk
    import irq_router_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [NLANE-1:0] bus_be,
    input logic             bus_we,
    input logic [NSRC-1:0]  en_mask,
    input logic [NSRC-1:0]  pol_mask,
    input logic [NSRC-1:0]  edge_mask,
    input logic [NSRC-1:0]  raw_st,
    input logic [NTGT-1:0]  irq_out
);
    logic [WIDX_W-1:0] word;
    logic              aligned;
    logic [NSRC-1:0]   wmask;
    logic [NSRC-1:0]   clr_req;
    logic              dead_wr;

    assign word    = bus_addr[AW-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wmask   = NSRC'(bus_wdata & lane_mask(bus_be));
    assign clr_req = (bus_we && aligned && word == W_RAW) ? wmask : '0;
    assign dead_wr = bus_we && (!aligned || word == 4'd13 || word == 4'd15);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (en_mask == '0 && pol_mask == '0 && edge_mask == '0));

    // R3
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && aligned && word == W_ENSET) |=> ((en_mask & $past(wmask)) == $past(wmask)));

    // R4
    enable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && aligned && word == W_ENCLR) |=> ((en_mask & $past(wmask)) == '0));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(raw_st) & $past(edge_mask) & edge_mask & ~raw_st & ~$past(clr_req)) == '0));

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0) |-> (irq_out == '0));

    // R9
    dead_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dead_wr |=> ($stable(en_mask) && $stable(pol_mask) && $stable(edge_mask)));
endmodule

bind irq_router_top irq_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_we(bus_we), .en_mask(en_mask), .pol_mask(pol_mask),
    .edge_mask(edge_mask), .raw_st(raw_st), .irq_out(irq_out)
);

// File: tb/irq_router_top_tb.sv
// Self-checking bench: sweeps every source over every target and both
// edge senses, plus register-access corner cases.
module irq_router_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic [15:0] irq_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rm [32];

    irq_router_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_out(input logic [31:0] pend);
        logic [15:0] r = '0;
        for (int s = 0; s < 32; s++)
            for (int c = 0; c < 4; c++)
                for (int p = 0; p < 4; p++)
                    if (pend[s] && rm[s][c] && rm[s][4+p]) r[c*4+p] = 1'b1;
        return r;
    endfunction

    task automatic set_route(input int s, input logic [7:0] b);
        wr(6'((s / 4) * 4), 32'(b) << (8 * (s % 4)), 4'(1 << (s % 4)));
        rm[s] = b;
    endtask

    initial begin
        #600000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] d;
        for (int s = 0; s < 32; s++) rm[s] = 8'h11;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int w = 0; w < 8; w++) begin
            rd(6'(w * 4), d); chk("R1 route reset", d, 32'h11111111);
        end
        rd(6'h28, d); chk("R1 enable reset", d, 32'h0);
        rd(6'h30, d); chk("R1 polarity reset", d, 32'h0);
        rd(6'h38, d); chk("R1 edge reset", d, 32'h0);
        // R5 level-low with inputs at 0 -> all asserted
        rd(6'h20, d); chk("R5 level-low raw", d, 32'hFFFFFFFF);
        rd(6'h24, d); chk("R7 pending none enabled", d, 32'h0);
        chk("R8 outputs quiet", 32'(irq_out), 32'h0);

        // R3 set with lane masking
        wr(6'h28, 32'hFFFFFFFF, 4'b0001);
        rd(6'h28, d); chk("R3 set lane0", d, 32'h000000FF);
        wr(6'h28, 32'h00000100, 4'b1111);
        rd(6'h28, d); chk("R3 set zero bits keep", d, 32'h000001FF);
        rd(6'h24, d); chk("R7 pending", d, 32'h000001FF);
        chk("R8 default route core0 pin0", 32'(irq_out), 32'h1);
        // R4 clear
        wr(6'h2C, 32'h0000000F, 4'b1111);
        rd(6'h28, d); chk("R4 clear", d, 32'h000001F0);
        wr(6'h2C, 32'hFFFFFFFF, 4'b0000);
        rd(6'h28, d); chk("R4 no lanes", d, 32'h000001F0);
        rd(6'h2C, d); chk("R4 read zero", d, 32'h0);
        // R10 mass disable, level mode
        wr(6'h2C, 32'hFFFFFFFF, 4'b1111);
        wr(6'h38, 32'h0, 4'b1111);
        rd(6'h24, d); chk("R10 pending", d, 32'h0);
        chk("R10 outputs", 32'(irq_out), 32'h0);

        // R2/R8 route sweep, level-high
        wr(6'h30, 32'hFFFFFFFF, 4'b1111);
        wr(6'h28, 32'hFFFFFFFF, 4'b1111);
        for (int s = 0; s < 32; s++) begin
            irq_in = 32'h1 << s;
            idle(3);
            rd(6'h20, d); chk("R5 level-high raw", d, 32'h1 << s);
            for (int t = 0; t < 16; t++) begin
                set_route(s, 8'((1 << (t / 4)) | (1 << (4 + t % 4))));
                #1 chk("R8 single target", 32'(irq_out), 32'(exp_out(irq_in)));
                chk("R8 index", 32'(irq_out), 32'h1 << t);
            end
        end
        for (int w = 0; w < 8; w++) begin
            rd(6'(w * 4), d);
            chk("R2 route readback", d, {rm[4*w+3], rm[4*w+2], rm[4*w+1], rm[4*w]});
        end
        // R8 multi and empty nibbles
        irq_in = 32'h1;
        idle(3);
        set_route(0, 8'h33);
        #1 chk("R8 fan-out", 32'(irq_out), 32'h0033);
        set_route(0, 8'h0F);
        #1 chk("R8 no pin", 32'(irq_out), 32'h0);
        set_route(0, 8'hF0);
        #1 chk("R8 no core", 32'(irq_out), 32'h0);
        set_route(0, 8'h11);

        // R5 level-low
        irq_in = 32'hA5A5_0F0F;
        wr(6'h30, 32'h0, 4'b1111);
        idle(3);
        rd(6'h20, d); chk("R5 level-low pattern", d, ~32'hA5A5_0F0F);
        // R6 W1C has no effect in level mode
        wr(6'h20, 32'hFFFFFFFF, 4'b1111);
        rd(6'h20, d); chk("R6 level ignores clear", d, ~32'hA5A5_0F0F);

        // R6 rising edges
        irq_in = '0;
        idle(3);
        wr(6'h30, 32'hFFFFFFFF, 4'b1111);
        wr(6'h38, 32'hFFFFFFFF, 4'b1111);
        wr(6'h20, 32'hFFFFFFFF, 4'b1111);
        rd(6'h20, d); chk("R6 edge start clear", d, 32'h0);
        for (int s = 0; s < 32; s++) begin
            irq_in = 32'h1 << s;
            idle(4);
            rd(6'h20, d); chk("R6 rising set", d, 32'h1 << s);
            chk("R8 edge routed", 32'(irq_out), 32'(exp_out(32'h1 << s)));
            irq_in = '0;
            idle(4);
            rd(6'h20, d); chk("R6 sticky", d, 32'h1 << s);
            wr(6'h20, 32'h1 << s, 4'b0000);
            rd(6'h20, d); chk("R6 clear needs lane", d, 32'h1 << s);
            wr(6'h20, 32'h1 << s, 4'b1111);
            rd(6'h20, d); chk("R6 clear", d, 32'h0);
        end
        // R6 falling edges
        wr(6'h30, 32'h0, 4'b1111);
        for (int s = 0; s < 32; s++) begin
            irq_in = 32'h1 << s;
            idle(4);
            rd(6'h20, d); chk("R6 falling no set on rise", d, 32'h0);
            irq_in = '0;
            idle(4);
            rd(6'h20, d); chk("R6 falling set", d, 32'h1 << s);
            wr(6'h20, 32'hFFFFFFFF, 4'b1111);
        end

        // R9 unmapped and misaligned
        wr(6'h34, 32'hFFFFFFFF, 4'b1111);
        wr(6'h3C, 32'hFFFFFFFF, 4'b1111);
        wr(6'h2D, 32'hFFFFFFFF, 4'b1111);
        wr(6'h31, 32'hFFFFFFFF, 4'b1111);
        rd(6'h34, d); chk("R9 read 0x34", d, 32'h0);
        rd(6'h3C, d); chk("R9 read 0x3C", d, 32'h0);
        rd(6'h29, d); chk("R9 misaligned read", d, 32'h0);
        rd(6'h28, d); chk("R9 enable kept", d, 32'hFFFFFFFF);
        rd(6'h30, d); chk("R9 polarity kept", d, 32'h0);
        rd(6'h38, d); chk("R9 edge kept", d, 32'hFFFFFFFF);

        report();
    end
endmodule